// File: doc/BRIEF.md
# Packet buffer page allocator

This block keeps track of a shared packet memory that is split into fixed 256-byte pages. The host drives an 8-bit command byte. The top three bits select an operation. For an allocation, the low five bits give the requested size as pages minus one. The block takes free pages one per cycle, lowest index first, and tags each page with the packet number. The packet number is the index of the first page taken. A failed allocation is reported in the result byte, and an allocation-done pulse marks the end of every host allocation, whether it succeeded or failed.

Packet numbers move through two small queues.

- **Transmit queue.** The host pushes a packet number onto it. A transmitter drains it through a valid/ready stream. A pop happens on a cycle where `tx_out_valid` and `tx_out_ready` are both high. The head stays stable until it is popped.
- **Receive queue.** A receiver asks for pages through a valid/ready request. `rx_req_ready` is high only while the block is idle and no command is being written in that cycle. An accepted request is either served or dropped; it is never held back. The request is served only if the free pages, after the count reserved for transmit is kept aside, can cover it and the receive queue has room. A served request appends its packet number to the receive queue.

The host can pop the receive head in two ways: one leaves the pages allocated and the other frees them. The host can also free any packet by number, reset everything, or clear the transmit queue alone. Freeing scans the page table and holds `busy` high for the whole scan. Commands written while busy are dropped.

Top module: `pbuf_page_alloc`

## Requirements
- R1: After reset, `mem_info` reads {free=NPAGES, total=NPAGES} (free in bits 15:8, total in bits 7:0). `queue_heads` reads 16'h8080, `busy` is 0, `alloc_result` is 0 and `tx_out_valid` is 0.
- R2: Command code 1 (bits 7:5 = 3'b001, bits 4:0 = pages-1) takes the lowest-numbered free pages, one per cycle, while `busy` is high for exactly that many cycles. When it ends, `alloc_result` = {1'b0, packet} with packet = index of the first page taken, `alloc_done` pulses for one cycle, and the free count has dropped by the page count.
- R3: If an allocation asks for more pages than are free, `alloc_result` becomes 8'h80 one cycle after the command. `alloc_done` pulses, `busy` stays low and the free count is unchanged.
- R4: Code 5 frees every page tagged with `sel_pkt`, keeping `busy` high for exactly NPAGES cycles.
- R5: Code 6 appends `sel_pkt` to the transmit queue. `queue_heads` bits 6:0 show the head and bit 7 is set when the queue is empty (bits 6:0 then read 0). A push while the queue already holds QDEPTH entries is dropped.
- R6: `tx_out_valid` is high while the transmit queue is not empty, and `tx_out_pkt` is its head. A cycle with `tx_out_valid` and `tx_out_ready` both high removes the head.
- R7: A receive request with `rx_req_pages` = pages-1 is accepted on a cycle with `rx_req_valid` and `rx_req_ready` both high. It allocates as in R2 and appends the packet number to the receive queue, without touching `alloc_result` or `alloc_done`. `queue_heads` bits 14:8 show the receive head and bit 15 is set when that queue is empty. If pages + `tx_reserve` exceeds the free count, or the receive queue is full, the request is dropped and takes no pages.
- R8: Code 3 removes the receive head and leaves its pages allocated. With the receive queue empty it does nothing.
- R9: Code 4 removes the receive head and frees its pages through an NPAGES-cycle busy scan. With the receive queue empty it does nothing.
- R10: Code 2 frees every page and empties both queues.
- R11: Code 7 empties only the transmit queue. Pages and the receive queue are unchanged.
- R12: Commands written while `busy` is high are dropped. `busy` never stays high for more than NPAGES consecutive cycles, and it only rises after an accepted command or request.
- R13: Code 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Operation in 7:5, pages-1 in 4:0 |
| sel_pkt | input | 7 | Packet number used by free and enqueue |
| tx_reserve | input | 5 | Pages kept back from receive allocations |
| rx_req_valid | input | 1 | Receive page request valid |
| rx_req_ready | output | 1 | Receive page request accepted |
| rx_req_pages | input | 5 | Receive request size, pages-1 |
| tx_out_valid | output | 1 | Transmit queue head valid |
| tx_out_ready | input | 1 | Transmitter takes the head |
| tx_out_pkt | output | 7 | Transmit queue head packet number |
| busy | output | 1 | Allocation or free scan in progress |
| alloc_result | output | 8 | Bit 7 failed, 6:0 packet number |
| alloc_done | output | 1 | One-cycle pulse at the end of a host allocation |
| queue_heads | output | 16 | {rx empty, rx head, tx empty, tx head} |
| mem_info | output | 16 | {free pages, total pages} |

## Verification
The bench sweeps every allocation size from one page to a full pool, then frees each packet by number. A design that numbered packets by anything other than the first page taken, or that miscounted pages, would report the wrong result byte or free count. It also mixes allocations with frees so that a later packet lands in non-contiguous pages. A design that assumed contiguous packets, or freed by range, would return the wrong pages. The bench checks the exact length of every busy window and writes a reset during an allocation. A design that shortened the scan or obeyed commands while busy would show a different busy count or lose the allocation. It also covers the receive reservation boundary, where a request exactly equal to the free pages left after the reservation must be served. Against full queues and the two receive dequeue codes, a swapped or missing free shows up directly in the free count.

// File: rtl/pba_pkg.sv
package pba_pkg;
  localparam int PKT_W = 7;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_ALLOC    = 3'd1,
    OP_RESET    = 3'd2,
    OP_RX_DROP  = 3'd3,
    OP_RX_FREE  = 3'd4,
    OP_FREE_PKT = 3'd5,
    OP_TX_PUSH  = 3'd6,
    OP_TX_RESET = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TAKE = 2'd1,
    ST_SCAN = 2'd2
  } st_e;
endpackage

// File: rtl/pba_fifo.sv
module pba_fifo #(
  parameter int W     = 7,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/pba_lowest.sv
module pba_lowest #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pba_pool.sv
module pba_pool #(
  parameter int NPAGES = 16,
  parameter int PKT_W  = 7,
  parameter int IW     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             take,
  input  logic [PKT_W-1:0] take_tag,
  input  logic             scan_en,
  input  logic [IW-1:0]    scan_idx,
  input  logic [PKT_W-1:0] scan_tag,
  output logic [IW-1:0]    low_idx,
  output logic [7:0]       free_cnt
);
  logic [NPAGES-1:0] free_map;
  logic [PKT_W-1:0]  owner [NPAGES];
  logic              any_free;
  logic              take_ok;
  logic              scan_hit;

  pba_lowest #(.N(NPAGES), .IW(IW)) u_low (
    .vec   (free_map),
    .found (any_free),
    .idx   (low_idx)
  );

  assign take_ok  = take && any_free;
  assign scan_hit = scan_en && !free_map[scan_idx] && (owner[scan_idx] == scan_tag);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      free_map <= '1;
      free_cnt <= 8'(NPAGES);
    end else begin
      if (take_ok)  free_map[low_idx]  <= 1'b0;
      if (scan_hit) free_map[scan_idx] <= 1'b1;
      free_cnt <= free_cnt - 8'(take_ok) + 8'(scan_hit);
    end
  end

  always_ff @(posedge clk) begin
    if (take_ok) owner[low_idx] <= take_tag;
  end
endmodule

// File: rtl/pbuf_page_alloc.sv
module pbuf_page_alloc #(
  parameter int NPAGES = 16,
  parameter int QDEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_byte,
  input  logic [6:0] sel_pkt,
  input  logic [4:0] tx_reserve,
  input  logic       rx_req_valid,
  output logic       rx_req_ready,
  input  logic [4:0] rx_req_pages,
  output logic       tx_out_valid,
  input  logic       tx_out_ready,
  output logic [6:0] tx_out_pkt,
  output logic       busy,
  output logic [7:0] alloc_result,
  output logic       alloc_done,
  output logic [15:0] queue_heads,
  output logic [15:0] mem_info
);
  import pba_pkg::*;

  localparam int IW = (NPAGES > 1) ? $clog2(NPAGES) : 1;

  st_e              st;
  logic [5:0]       remain;
  logic [PKT_W-1:0] pkt_r;
  logic             first_r;
  logic             to_rx;
  logic [IW-1:0]    scan_i;
  logic [PKT_W-1:0] scan_tag;

  logic [IW-1:0]    low_idx;
  logic [7:0]       free_cnt;
  logic [PKT_W-1:0] take_tag;

  logic [PKT_W-1:0] tx_head, rx_head;
  logic             tx_empty, tx_full, rx_empty, rx_full;

  op_e        op;
  logic [5:0] need, rx_need;
  logic       idle, cmd_go, rx_go, host_fits, rx_fits;
  logic       clr_all, take, scan_en;
  logic       tx_push, tx_pop, tx_flush, rx_push, rx_pop, rx_flush;
  logic       last_take;

  assign op        = op_e'(cmd_byte[7:5]);
  assign need      = {1'b0, cmd_byte[4:0]} + 6'd1;
  assign rx_need   = {1'b0, rx_req_pages} + 6'd1;
  assign idle      = (st == ST_IDLE);
  assign cmd_go    = cmd_we && idle;
  assign rx_req_ready = idle && !cmd_we;
  assign rx_go     = rx_req_valid && rx_req_ready;
  assign host_fits = ({2'b00, need} <= free_cnt);
  assign rx_fits   = (({3'b000, rx_need} + {4'b0000, tx_reserve}) <= {1'b0, free_cnt})
                     && !rx_full;

  assign clr_all   = cmd_go && (op == OP_RESET);
  assign take      = (st == ST_TAKE);
  assign scan_en   = (st == ST_SCAN);
  assign take_tag  = first_r ? PKT_W'(low_idx) : pkt_r;
  assign last_take = take && (remain == 6'd1);

  assign tx_push  = cmd_go && (op == OP_TX_PUSH) && !tx_full;
  assign tx_flush = cmd_go && ((op == OP_RESET) || (op == OP_TX_RESET));
  assign tx_pop   = tx_out_ready && !tx_empty && !tx_flush;
  assign rx_flush = clr_all;
  assign rx_pop   = cmd_go && ((op == OP_RX_DROP) || (op == OP_RX_FREE)) && !rx_empty;
  assign rx_push  = last_take && to_rx;

  pba_pool #(.NPAGES(NPAGES), .PKT_W(PKT_W), .IW(IW)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (clr_all),
    .take     (take),
    .take_tag (take_tag),
    .scan_en  (scan_en),
    .scan_idx (scan_i),
    .scan_tag (scan_tag),
    .low_idx  (low_idx),
    .free_cnt (free_cnt)
  );

  pba_fifo #(.W(PKT_W), .DEPTH(QDEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_flush),
    .push  (tx_push),
    .din   (sel_pkt),
    .pop   (tx_pop),
    .dout  (tx_head),
    .empty (tx_empty),
    .full  (tx_full)
  );

  pba_fifo #(.W(PKT_W), .DEPTH(QDEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_flush),
    .push  (rx_push),
    .din   (take_tag),
    .pop   (rx_pop),
    .dout  (rx_head),
    .empty (rx_empty),
    .full  (rx_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      remain       <= '0;
      pkt_r        <= '0;
      first_r      <= 1'b0;
      to_rx        <= 1'b0;
      scan_i       <= '0;
      scan_tag     <= '0;
      alloc_result <= '0;
      alloc_done   <= 1'b0;
    end else begin
      alloc_done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_go) begin
            case (op)
              OP_ALLOC: begin
                if (host_fits) begin
                  st      <= ST_TAKE;
                  remain  <= need;
                  first_r <= 1'b1;
                  to_rx   <= 1'b0;
                end else begin
                  alloc_result <= 8'h80;
                  alloc_done   <= 1'b1;
                end
              end
              OP_RX_FREE: begin
                if (!rx_empty) begin
                  st       <= ST_SCAN;
                  scan_i   <= '0;
                  scan_tag <= rx_head;
                end
              end
              OP_FREE_PKT: begin
                st       <= ST_SCAN;
                scan_i   <= '0;
                scan_tag <= sel_pkt;
              end
              default: ;
            endcase
          end else if (rx_go && rx_fits) begin
            st      <= ST_TAKE;
            remain  <= rx_need;
            first_r <= 1'b1;
            to_rx   <= 1'b1;
          end
        end
        ST_TAKE: begin
          first_r <= 1'b0;
          if (first_r) pkt_r <= PKT_W'(low_idx);
          remain <= remain - 6'd1;
          if (last_take) begin
            st <= ST_IDLE;
            if (!to_rx) begin
              alloc_result <= {1'b0, take_tag};
              alloc_done   <= 1'b1;
            end
          end
        end
        ST_SCAN: begin
          scan_i <= scan_i + IW'(1);
          if (scan_i == IW'(NPAGES - 1)) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy         = !idle;
  assign tx_out_valid = !tx_empty;
  assign tx_out_pkt   = tx_head;
  assign queue_heads  = {rx_empty, rx_empty ? 7'd0 : rx_head,
                         tx_empty, tx_empty ? 7'd0 : tx_head};
  assign mem_info     = {free_cnt, 8'(NPAGES)};
endmodule

// File: rtl/pba_chk.sv
module pba_chk #(
  parameter int NPAGES = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic        rx_req_valid,
  input logic        rx_req_ready,
  input logic        tx_out_valid,
  input logic        busy,
  input logic [7:0]  alloc_result,
  input logic        alloc_done,
  input logic [15:0] queue_heads,
  input logic [15:0] mem_info
);
  logic [8:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_run <= '0;
    else        busy_run <= busy ? busy_run + 9'd1 : 9'd0;
  end

  // R12
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= 9'(NPAGES));

  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cmd_we) || $past(rx_req_valid && rx_req_ready)));

  // R3
  fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_done && alloc_result[7]) |-> (mem_info[15:8] == $past(mem_info[15:8])));

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |-> !busy);

  // R7
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req_ready |-> !busy);

  // R1
  free_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_info[15:8] <= mem_info[7:0]);

  // R6
  tx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid == !queue_heads[7]);
endmodule

bind pbuf_page_alloc pba_chk #(.NPAGES(NPAGES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_we       (cmd_we),
  .rx_req_valid (rx_req_valid),
  .rx_req_ready (rx_req_ready),
  .tx_out_valid (tx_out_valid),
  .busy         (busy),
  .alloc_result (alloc_result),
  .alloc_done   (alloc_done),
  .queue_heads  (queue_heads),
  .mem_info     (mem_info)
);

// File: tb/sim_pbuf_page_alloc.sv
`timescale 1ns/1ps
module sim_pbuf_page_alloc;
  localparam int NP = 16;
  localparam int QD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic [6:0] sel_pkt = '0;
  logic [4:0] tx_reserve = '0;
  logic       rx_req_valid = 1'b0;
  logic       rx_req_ready;
  logic [4:0] rx_req_pages = '0;
  logic       tx_out_valid;
  logic       tx_out_ready = 1'b0;
  logic [6:0] tx_out_pkt;
  logic       busy;
  logic [7:0] alloc_result;
  logic       alloc_done;
  logic [15:0] queue_heads;
  logic [15:0] mem_info;

  pbuf_page_alloc #(.NPAGES(NP), .QDEPTH(QD)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .sel_pkt(sel_pkt), .tx_reserve(tx_reserve),
    .rx_req_valid(rx_req_valid), .rx_req_ready(rx_req_ready),
    .rx_req_pages(rx_req_pages), .tx_out_valid(tx_out_valid),
    .tx_out_ready(tx_out_ready), .tx_out_pkt(tx_out_pkt), .busy(busy),
    .alloc_result(alloc_result), .alloc_done(alloc_done),
    .queue_heads(queue_heads), .mem_info(mem_info)
  );

  always #2.5 clk = ~clk;

  int  vectors = 0;
  int  errors = 0;
  bit  finished = 0;
  bit  done_seen;
  int  busy_cycles;

  bit  mfree [NP];
  int  mown  [NP];
  int  txq [$];
  int  rxq [$];

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int mcnt();
    int c = 0;
    for (int p = 0; p < NP; p++) if (mfree[p]) c++;
    return c;
  endfunction

  function automatic int m_alloc(int n);
    int pkt = -1;
    if (mcnt() < n) return -1;
    for (int k = 0; k < n; k++) begin
      bit got = 0;
      for (int p = 0; p < NP; p++) begin
        if (!got && mfree[p]) begin
          got = 1;
          if (pkt < 0) pkt = p;
          mfree[p] = 0;
          mown[p] = pkt;
        end
      end
    end
    return pkt;
  endfunction

  function automatic void m_free(int tag);
    for (int p = 0; p < NP; p++) if (!mfree[p] && mown[p] == tag) mfree[p] = 1;
  endfunction

  function automatic void m_reset_pages();
    for (int p = 0; p < NP; p++) begin mfree[p] = 1; mown[p] = 0; end
  endfunction

  function automatic logic [15:0] exp_heads();
    logic [15:0] h;
    h[15]   = (rxq.size() == 0);
    h[14:8] = (rxq.size() == 0) ? 7'd0 : 7'(rxq[0]);
    h[7]    = (txq.size() == 0);
    h[6:0]  = (txq.size() == 0) ? 7'd0 : 7'(txq[0]);
    return h;
  endfunction

  task automatic check_state(string req);
    check({req, " mem_info"}, 32'(mem_info), 32'({8'(mcnt()), 8'(NP)}));
    check({req, " queue_heads"}, 32'(queue_heads), 32'(exp_heads()));
  endtask

  task automatic poll_idle();
    done_seen = 0;
    busy_cycles = 0;
    for (int g = 0; g < 200; g++) begin
      if (alloc_done) done_seen = 1;
      if (!busy) break;
      busy_cycles++;
      @(negedge clk);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [4:0] low);
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_byte = {op, low};
    @(posedge clk);
    @(negedge clk);
    cmd_we = 1'b0;
    poll_idle();
  endtask

  task automatic rx_req(logic [4:0] pg);
    @(negedge clk);
    check("R7 ready when idle", 32'(rx_req_ready), 32'd1);
    rx_req_valid = 1'b1;
    rx_req_pages = pg;
    @(posedge clk);
    @(negedge clk);
    rx_req_valid = 1'b0;
    poll_idle();
  endtask

  task automatic host_alloc(int n, string req);
    int pkt;
    pkt = m_alloc(n);
    issue(3'd1, 5'(n - 1));
    if (pkt < 0) begin
      check({req, " fail result"}, 32'(alloc_result), 32'h80);
      check({req, " fail busy"}, 32'(busy_cycles), 32'd0);
    end else begin
      check({req, " result"}, 32'(alloc_result), 32'(pkt));
      check({req, " busy cycles"}, 32'(busy_cycles), 32'(n));
    end
    check({req, " done pulse"}, 32'(done_seen), 32'd1);
    check_state(req);
  endtask

  task automatic free_pkt(int tag, string req);
    sel_pkt = 7'(tag);
    m_free(tag);
    issue(3'd5, 5'd0);
    check({req, " scan cycles"}, 32'(busy_cycles), 32'(NP));
    check_state(req);
  endtask

  task automatic model_rx(int pg);
    int pkt;
    if ((pg + int'(tx_reserve)) <= mcnt() && rxq.size() < QD) begin
      pkt = m_alloc(pg);
      rxq.push_back(pkt);
    end
  endtask

  task automatic full_reset();
    issue(3'd2, 5'd0);
    m_reset_pages();
    txq.delete();
    rxq.delete();
    check_state("R10 reset");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    m_reset_pages();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mem_info", 32'(mem_info), 32'h1010);
    check("R1 queue_heads", 32'(queue_heads), 32'h8080);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 alloc_result", 32'(alloc_result), 32'd0);
    check("R1 tx_out_valid", 32'(tx_out_valid), 32'd0);

    // R2 / R4: every size, then free by number
    for (int n = 1; n <= NP; n++) begin
      host_alloc(n, "R2 sweep");
      free_pkt(0, "R4 sweep free");
    end

    // R2 / R3: fragmented pool
    host_alloc(3, "R2 frag a");
    host_alloc(5, "R2 frag b");
    host_alloc(2, "R2 frag c");
    free_pkt(3, "R4 frag free");
    host_alloc(7, "R2 frag spread");
    host_alloc(8, "R3 too big");
    host_alloc(4, "R2 exact fill");
    host_alloc(1, "R3 empty pool");

    // R13 no-op leaves state alone
    issue(3'd0, 5'd7);
    check("R13 nop busy", 32'(busy_cycles), 32'd0);
    check_state("R13 nop");
    full_reset();

    // R5 / R6 transmit queue
    for (int k = 0; k < QD + 1; k++) begin
      sel_pkt = 7'(5 + 3 * k);
      if (txq.size() < QD) txq.push_back(5 + 3 * k);
      issue(3'd6, 5'd0);
      check_state("R5 enqueue");
    end
    for (int k = 0; k < QD; k++) begin
      @(negedge clk);
      check("R6 valid", 32'(tx_out_valid), 32'd1);
      check("R6 head", 32'(tx_out_pkt), 32'(txq[0]));
      tx_out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tx_out_ready = 1'b0;
      void'(txq.pop_front());
      check_state("R6 pop");
    end
    check("R6 drained", 32'(tx_out_valid), 32'd0);

    // R7 receive allocations
    model_rx(3); rx_req(5'd2); check_state("R7 rx a");
    model_rx(1); rx_req(5'd0); check_state("R7 rx b");

    // R11 TX reset keeps pages and RX queue
    sel_pkt = 7'd9; txq.push_back(9); issue(3'd6, 5'd0);
    sel_pkt = 7'd2; txq.push_back(2); issue(3'd6, 5'd0);
    check_state("R5 before tx reset");
    txq.delete();
    issue(3'd7, 5'd0);
    check_state("R11 tx reset");

    // R8 remove without free
    void'(rxq.pop_front());
    issue(3'd3, 5'd0);
    check("R8 no scan", 32'(busy_cycles), 32'd0);
    check_state("R8 remove");

    // R9 release frees pages
    m_free(rxq.pop_front());
    issue(3'd4, 5'd0);
    check("R9 scan cycles", 32'(busy_cycles), 32'(NP));
    check_state("R9 release");
    issue(3'd4, 5'd0);
    check("R9 empty ignored", 32'(busy_cycles), 32'd0);
    check_state("R9 empty");
    issue(3'd3, 5'd0);
    check_state("R8 empty");
    free_pkt(0, "R4 after remove");

    // R7 reservation boundary
    tx_reserve = 5'd10;
    model_rx(8); rx_req(5'd7); check_state("R7 reserve drop");
    model_rx(6); rx_req(5'd5); check_state("R7 reserve exact");
    tx_reserve = 5'd0;
    for (int k = 0; k < QD; k++) begin
      model_rx(1); rx_req(5'd0); check_state("R7 rx fill");
    end
    check("R7 full queue count", 32'(rxq.size()), 32'(QD));
    full_reset();

    // R12 command while busy is dropped
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_byte = {3'd1, 5'd7};
    void'(m_alloc(8));
    @(posedge clk);
    @(negedge clk);
    check("R12 busy seen", 32'(busy), 32'd1);
    cmd_byte = {3'd2, 5'd0};
    @(posedge clk);
    @(negedge clk);
    cmd_we = 1'b0;
    poll_idle();
    check("R12 alloc kept result", 32'(alloc_result), 32'd0);
    check_state("R12 ignored reset");
    full_reset();

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule